// File: doc/BRIEF.md
# I2C Bus Condition Monitor with Master Timeout

This block observes the raw clock and data lines of an I2C bus and turns them into bus-level status for a controller. Both lines pass through a two-flop synchronizer. The synchronized samples feed a detector that finds START, repeated START and STOP conditions. The detector keeps a flag that shows whether the bus is occupied and emits one-cycle pulses for START and STOP. The synchronized clock level is also brought out so the host logic can read it.

When the controller acts as a bus master, two independent timers guard against a hung bus. The first counts clock cycles while the bus clock stays low. The second counts cycles while a local START request waits on a bus that another device holds. Each timer compares its count with a programmable limit and raises a timeout pulse once per episode. Clearing the module enable forces the monitor idle: the busy flag drops, no event pulses appear and both timers are held cleared.

Top module: `i2c_bus_watch`

## Requirements
- R1: `scl_level` equals the SCL input delayed by exactly two clock cycles, and reads 1 for a high line and 0 for a low line.
- R2: While SCL is high on two consecutive synchronized samples, a falling edge on synchronized SDA gives one `start_evt` pulse and sets `bus_busy` to 1. This includes a repeated START while the bus is already busy.
- R3: While SCL is high on two consecutive synchronized samples, a rising edge on synchronized SDA gives a `stop_evt` pulse that lasts exactly one cycle and clears `bus_busy` to 0.
- R4: SDA edges while SCL is low produce no START or STOP event and leave `bus_busy` unchanged.
- R5: While `enable` is 0, `bus_busy` is 0, and `start_evt`, `stop_evt` and `timeout_evt` stay 0. A busy bus reads not busy within two cycles of `enable` falling.
- R6: With `enable`=1, `master_mode`=1 and `timeout_lim`=L>0, a synchronized SCL low period of D cycles gives exactly one `timeout_evt` pulse if D>L, and none otherwise.
- R7: With `enable`=1, `master_mode`=1 and L>0, holding `start_req` for D cycles while `bus_busy` is 1 gives exactly one `timeout_evt` pulse if D>L, and none otherwise.
- R8: `timeout_lim`=0 disables both timeouts, however long the condition lasts.
- R9: With `master_mode`=0, no timeout is raised.
- R10: After reset, `bus_busy`, `start_evt`, `stop_evt` and `timeout_evt` are 0, and `scl_level` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Module enable; 0 forces the monitor idle |
| master_mode | input | 1 | Arms the timeout timers |
| start_req | input | 1 | Local request to issue a START |
| timeout_lim | input | TW | Timeout limit in clock cycles; 0 disables |
| scl_in | input | 1 | Raw SCL line |
| sda_in | input | 1 | Raw SDA line |
| scl_level | output | 1 | Synchronized SCL level |
| bus_busy | output | 1 | Bus occupied, from START until STOP |
| start_evt | output | 1 | One-cycle pulse on START or repeated START |
| stop_evt | output | 1 | One-cycle pulse on STOP |
| timeout_evt | output | 1 | One-cycle timeout pulse |

## Verification
The assertions assume that SDA and SCL never change in the same sample on the synchronized side. They also assume that `enable`, `master_mode` and `timeout_lim` are held steady during any timed episode, so that one low period or one START wait maps to a single count. The stimulus keeps to this in two ways. Every line change is driven on the falling clock edge and held for at least one full cycle, with SDA and SCL never changing together. Control inputs change only while the lines are idle. The random episode lengths and limits are drawn so that both sides of the D>L boundary, including D equal to L, come up often.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;

    typedef struct packed {
        logic scl_prev;
        logic sda_prev;
        logic start;
        logic stop;
        logic busy;
    } det_state_t;

    localparam int unsigned NUM_TIMERS = 2;
    localparam int unsigned TMR_SCL    = 0;
    localparam int unsigned TMR_START  = 1;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int unsigned LINES  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_in,
    output logic [LINES-1:0] sync_out
);

    logic [LINES-1:0][STAGES-1:0] sh_d, sh_q;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_comb begin
            sh_d[i] = {sh_q[i][STAGES-2:0], raw_in[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q[i] <= '1;
            else        sh_q[i] <= sh_d[i];
        end

        assign sync_out[i] = sh_q[i][STAGES-1];
    end

endmodule

// File: rtl/cond_detect.sv
module cond_detect
    import i2c_watch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_evt,
    output logic stop_evt,
    output logic busy
);

    det_state_t st_d, st_q;
    logic       scl_hi_both;
    logic       is_start;
    logic       is_stop;

    always_comb begin
        scl_hi_both = st_q.scl_prev & scl_s;
        is_start    = scl_hi_both & st_q.sda_prev & ~sda_s;
        is_stop     = scl_hi_both & ~st_q.sda_prev & sda_s;

        st_d          = st_q;
        st_d.scl_prev = scl_s;
        st_d.sda_prev = sda_s;
        st_d.start    = enable & is_start;
        st_d.stop     = enable & is_stop;
        if (!enable)       st_d.busy = 1'b0;
        else if (is_start) st_d.busy = 1'b1;
        else if (is_stop)  st_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{scl_prev: 1'b1, sda_prev: 1'b1, default: 1'b0};
        else        st_q <= st_d;
    end

    assign start_evt = st_q.start;
    assign stop_evt  = st_q.stop;
    assign busy      = st_q.busy;

    // R5
    off_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && !start_evt && !stop_evt));
    // R3
    stop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !stop_evt);
    // R3
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |-> !busy);
    // R2
    start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |-> busy);
    // R4
    scl_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scl_s |=> (!start_evt && !stop_evt));

endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          fire
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
        logic          fire;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (!run || limit == '0) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (st_q.cnt >= limit) begin
            st_d.fire = ~st_q.done;
            st_d.done = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire = st_q.fire;

    // R6
    fire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
    // R8
    zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0) |=> !fire);
    // R9
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.cnt == '0 && !fire));

endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
    import i2c_watch_pkg::*;
#(
    parameter int unsigned TW         = 16,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          master_mode,
    input  logic          start_req,
    input  logic [TW-1:0] timeout_lim,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_level,
    output logic          bus_busy,
    output logic          start_evt,
    output logic          stop_evt,
    output logic          timeout_evt
);

    localparam int unsigned LINES = 2;

    logic [LINES-1:0]      lines_s;
    logic                  scl_s, sda_s;
    logic                  armed;
    logic [NUM_TIMERS-1:0] tmr_run;
    logic [NUM_TIMERS-1:0] tmr_fire;

    line_sync #(.LINES(LINES), .STAGES(SYNC_DEPTH)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   ({sda_in, scl_in}),
        .sync_out (lines_s)
    );

    assign scl_s = lines_s[0];
    assign sda_s = lines_s[1];

    cond_detect i_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .busy      (bus_busy)
    );

    always_comb begin
        armed               = enable & master_mode;
        tmr_run             = '0;
        tmr_run[TMR_SCL]    = armed & ~scl_s;
        tmr_run[TMR_START]  = armed & start_req & bus_busy;
    end

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
        idle_timer #(.CW(TW)) i_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (tmr_run[t]),
            .limit (timeout_lim),
            .fire  (tmr_fire[t])
        );
    end

    assign timeout_evt = |tmr_fire;
    assign scl_level   = scl_s;

    // R9
    slave_no_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |=> !timeout_evt);
    // R1
    scl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_level) |-> $past(scl_in, 2));

endmodule

// File: tb/test_i2c_bus_watch.sv
module test_i2c_bus_watch;

    localparam int CLK_PERIOD = 10;
    localparam int TW         = 16;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          enable = 0, master_mode = 0, start_req = 0;
    logic [TW-1:0] timeout_lim = '0;
    logic          scl_in = 1, sda_in = 1;
    logic          scl_level, bus_busy, start_evt, stop_evt, timeout_evt;

    int n_checks = 0, n_errors = 0;
    int n_start = 0, n_stop = 0, n_to = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_bus_watch #(.TW(TW)) i_i2c_bus_watch (
        .clk(clk), .rst_n(rst_n), .enable(enable), .master_mode(master_mode),
        .start_req(start_req), .timeout_lim(timeout_lim),
        .scl_in(scl_in), .sda_in(sda_in), .scl_level(scl_level),
        .bus_busy(bus_busy), .start_evt(start_evt), .stop_evt(stop_evt),
        .timeout_evt(timeout_evt)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            n_start += int'(start_evt);
            n_stop  += int'(stop_evt);
            n_to    += int'(timeout_evt);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic check(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int exp_to(input bit en, input bit m, input int lim, input int d);
        return (en && m && lim != 0 && d > lim) ? 1 : 0;
    endfunction

    task automatic bus_start();
        scl_in = 1; cycles(3);
        sda_in = 1; cycles(3);
        sda_in = 0; cycles(4);
    endtask

    task automatic bus_restart();
        scl_in = 0; cycles(1);
        sda_in = 1; cycles(1);
        scl_in = 1; cycles(3);
        sda_in = 0; cycles(4);
    endtask

    task automatic bus_stop();
        scl_in = 0; cycles(1);
        sda_in = 0; cycles(1);
        scl_in = 1; cycles(3);
        sda_in = 1; cycles(4);
    endtask

    int s0, p0, t0;

    initial begin
        void'($urandom(2024));
        cycles(3);
        rst_n = 1;
        cycles(1);
        // R10 reset state
        check(bus_busy, 0, "R10 busy");
        check(start_evt | stop_evt, 0, "R10 events");
        check(timeout_evt, 0, "R10 timeout");
        check(scl_level, 1, "R10 scl_level");

        enable = 1;
        cycles(2);
        // R1 two-cycle latency
        scl_in = 0;
        cycles(1);
        check(scl_level, 1, "R1 after one cycle");
        cycles(1);
        check(scl_level, 0, "R1 after two cycles");
        scl_in = 1;
        cycles(2);
        check(scl_level, 1, "R1 high again");

        // R2 start and repeated start
        s0 = n_start;
        bus_start();
        check(n_start - s0, 1, "R2 start pulse");
        check(bus_busy, 1, "R2 busy set");
        bus_restart();
        check(n_start - s0, 2, "R2 repeated start");
        check(bus_busy, 1, "R2 busy kept");

        // R4 SDA toggles with SCL low
        s0 = n_start; p0 = n_stop;
        scl_in = 0; cycles(2);
        for (int k = 0; k < 6; k++) begin sda_in = ~sda_in; cycles(2); end
        sda_in = 0; cycles(2);
        scl_in = 1; cycles(4);
        check(n_start - s0 + n_stop - p0, 0, "R4 no events");
        check(bus_busy, 1, "R4 busy unchanged");

        // R3 stop
        p0 = n_stop;
        bus_stop();
        check(n_stop - p0, 1, "R3 one-cycle stop pulse");
        check(bus_busy, 0, "R3 busy cleared");

        // R5 disable
        bus_start();
        enable = 0;
        cycles(2);
        check(bus_busy, 0, "R5 busy dropped");
        s0 = n_start; p0 = n_stop; t0 = n_to;
        master_mode = 1; timeout_lim = 3;
        bus_stop(); bus_start();
        scl_in = 0; cycles(10); scl_in = 1; cycles(4);
        check(n_start - s0 + n_stop - p0, 0, "R5 no events");
        check(n_to - t0, 0, "R5 no timeout");
        check(bus_busy, 0, "R5 busy stays 0");
        bus_stop();
        master_mode = 0;
        enable = 1;
        cycles(3);

        // R6 random SCL-low episodes
        master_mode = 1;
        for (int it = 0; it < 40; it++) begin
            int lim, d;
            lim = 1 + int'($urandom % 12);
            d   = 1 + int'($urandom % 20);
            if (it % 4 == 0) d = lim;
            if (it % 4 == 1) d = lim + 1;
            timeout_lim = TW'(lim);
            cycles(2);
            t0 = n_to;
            scl_in = 0; cycles(d);
            scl_in = 1; cycles(6);
            check(n_to - t0, exp_to(1, 1, lim, d), $sformatf("R6 lim=%0d d=%0d", lim, d));
        end

        // R7 random START-wait episodes
        for (int it = 0; it < 30; it++) begin
            int lim, d;
            lim = 1 + int'($urandom % 12);
            d   = 1 + int'($urandom % 20);
            if (it % 3 == 0) d = lim;
            timeout_lim = TW'(lim);
            master_mode = 0;
            bus_start();
            master_mode = 1;
            t0 = n_to;
            start_req = 1; cycles(d);
            start_req = 0; cycles(4);
            check(n_to - t0, exp_to(1, 1, lim, d), $sformatf("R7 lim=%0d d=%0d", lim, d));
            master_mode = 0;
            bus_stop();
        end

        // R8 zero limit
        master_mode = 1; timeout_lim = 0;
        t0 = n_to;
        scl_in = 0; cycles(40); scl_in = 1; cycles(4);
        master_mode = 0; bus_start(); master_mode = 1;
        start_req = 1; cycles(40); start_req = 0; cycles(4);
        check(n_to - t0, 0, "R8 zero limit");
        master_mode = 0; bus_stop();

        // R9 slave mode
        timeout_lim = 2;
        t0 = n_to;
        scl_in = 0; cycles(30); scl_in = 1; cycles(4);
        check(n_to - t0, 0, "R9 slave no timeout");

        // R6 long low, saturating: a single pulse
        master_mode = 1; timeout_lim = 5;
        cycles(2);
        t0 = n_to;
        scl_in = 0; cycles(200); scl_in = 1; cycles(4);
        check(n_to - t0, 1, "R6 saturate single pulse");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule